// File: doc/BRIEF.md
# Guarded Page Programming Controller

This block sits behind the serial-bus slave of a small 128-byte configuration memory. When the bus front end has finished collecting a page write and has seen the closing stop condition, it presents a base address, up to eight captured bytes with a valid bit for each, and a one-cycle commit strobe. The controller decides from two pin levels and an internal sticky lock bit whether the write may proceed. If it may, the controller runs a timed programming interval and places the bytes into the array at its end. During the interval it holds a busy flag, which the slave uses to withhold acknowledges.

Permission has three inputs. The level of the transmit-clock pin is a master write enable. The protect pin is active low. The lock bit starts cleared after reset and is set permanently by any accepted write that lands on the highest address. Until the lock is set, the protect pin has no effect. The bytes of one commit stay inside one aligned eight-byte page: the low three address bits advance from the base and wrap, and the upper bits stay fixed. The length of the programming interval is a parameter in system clocks. A second parameter, `BUSY_ON_BLOCK`, selects whether a refused commit also holds busy for one interval; it defaults to off. A read port gives combinational access to the array.

Top module: `wprot_prog_ctrl`

## Requirements
- R1: When `xclk_level` is 0 in the commit cycle, the commit is refused: no array byte and not the lock bit change, whatever `protect_pin` and the lock bit hold.
- R2: After reset the lock bit is clear; while it is clear, a commit with `xclk_level` = 1 is accepted for either level of `protect_pin`.
- R3: An accepted commit that writes any valid byte to address 127 (7Fh) sets the lock bit, which then stays set until reset.
- R4: With the lock bit set and `xclk_level` = 1, a commit is accepted when `protect_pin` = 1 and refused when `protect_pin` = 0.
- R5: Slot k (bits 8k+7..8k of `page_bytes`) goes to address {`base_addr`[6:3], (`base_addr`[2:0] + k) mod 8}, and only when `byte_valid`[k] = 1; every other address keeps its value.
- R6: For an accepted commit sampled at clock edge E0, `busy` is 1 for exactly `WR_CYCLES` cycles starting right after E0. The array update is visible, and `done` is 1 for one cycle, in the first cycle with `busy` back at 0.
- R7: Once programming has started, it completes unchanged when `xclk_level`, `protect_pin`, the data inputs or `commit` change while `busy` = 1; a commit strobe seen while busy is ignored.
- R8: With `BUSY_ON_BLOCK` = 0, a refused commit sampled at edge E0 gives `done` = 1 for the cycle right after E0 and keeps `busy` at 0.
- R9: After reset `busy` and `done` are 0 and every array byte reads 0.
- R10: `rd_data` shows the byte at `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| commit | input | 1 | One-cycle strobe from the front end after the stop condition |
| base_addr | input | 7 | Word address of the first captured byte |
| page_bytes | input | 64 | Captured bytes, slot k in bits 8k+7..8k |
| byte_valid | input | 8 | One valid bit for each slot |
| xclk_level | input | 1 | Level of the transmit-clock pin; 1 enables writing |
| protect_pin | input | 1 | Protect pin level; 0 protects once the lock bit is set |
| rd_addr | input | 7 | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |
| busy | output | 1 | Programming interval in progress |
| done | output | 1 | One-cycle pulse when a commit has been fully handled |

## Verification
If the lock bit is wrong, the fault stays hidden until the next commit with `protect_pin` low. That commit then either changes array bytes it should not change or leaves them unchanged when it should write, and a sweep of the read port after `done` shows this. A wrong interval counter or state shows up at the first commit as a busy run of the wrong length, or as a missing or misplaced `done` pulse. A wrong slot address shows up as misplaced bytes in the sweep that follows that same commit. Random page writes with mixed valid masks, wrapping bases and both pin levels give every slot-to-address pairing and every permission case a chance to fail against the bench's own model of the array.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int SLOT_W = 3;
    localparam int SLOTS  = 1 << SLOT_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam addr_t LOCK_ADDR = addr_t'(DEPTH - 1);

    // Captured commit: base address, per-slot valid bits, packed slot bytes.
    typedef struct packed {
        addr_t                    base;
        logic [SLOTS-1:0]         valid;
        logic [SLOTS*DATA_W-1:0]  bytes;
    } page_req_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PROG = 1'b1
    } prog_state_e;

    // Address of slot k: page bits fixed, low bits wrap within the page.
    function automatic addr_t slot_target(addr_t base, int unsigned k);
        logic [SLOT_W-1:0] lo;
        lo = base[SLOT_W-1:0] + SLOT_W'(k);
        return {base[ADDR_W-1:SLOT_W], lo};
    endfunction

    // Master enable from the transmit clock level, then pin gated by the lock.
    function automatic logic may_write(logic xclk_hi, logic pin_hi, logic lock);
        return xclk_hi & (~lock | pin_hi);
    endfunction

endpackage

// File: rtl/wpc_permit.sv
module wpc_permit
    import wpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             xclk_level,
    input  logic             protect_pin,
    input  logic             fire,
    input  addr_t            base,
    input  logic [SLOTS-1:0] valid,
    output logic             allow,
    output logic             lock
);

    logic             lock_q;
    logic [SLOTS-1:0] hits;

    for (genvar k = 0; k < SLOTS; k++) begin : g_hit
        assign hits[k] = valid[k] && (slot_target(base, k) == LOCK_ADDR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (fire && (|hits)) begin
            lock_q <= 1'b1;
        end
    end

    assign allow = may_write(xclk_level, protect_pin, lock_q);
    assign lock  = lock_q;

endmodule

// File: rtl/wpc_timer.sv
module wpc_timer
    import wpc_pkg::*;
#(
    parameter int WR_CYCLES     = 16,
    parameter bit BUSY_ON_BLOCK = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic grant,
    output logic busy,
    output logic fire,
    output logic done
);

    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    prog_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wr_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (grant || BUSY_ON_BLOCK) begin
                            state_q <= ST_PROG;
                            cnt_q   <= CNT_W'(WR_CYCLES - 1);
                            wr_q    <= grant;
                        end else begin
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_PROG: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_IDLE;
                        wr_q    <= 1'b0;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q == ST_PROG);
    assign fire = busy && (cnt_q == '0) && wr_q;
    assign done = done_q;

endmodule

// File: rtl/wpc_array.sv
module wpc_array
    import wpc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  page_req_t req,
    input  addr_t     rd_addr,
    output byte_t     rd_data
);

    byte_t mem [DEPTH];
    addr_t tgt [SLOTS];
    byte_t val [SLOTS];

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign tgt[k] = slot_target(req.base, k);
        assign val[k] = req.bytes[k*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (fire) begin
            for (int k = 0; k < SLOTS; k++) begin
                if (req.valid[k]) begin
                    mem[tgt[k]] <= val[k];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/wprot_prog_ctrl.sv
module wprot_prog_ctrl
    import wpc_pkg::*;
#(
    parameter int WR_CYCLES     = 16,
    parameter bit BUSY_ON_BLOCK = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    commit,
    input  logic [ADDR_W-1:0]       base_addr,
    input  logic [SLOTS*DATA_W-1:0] page_bytes,
    input  logic [SLOTS-1:0]        byte_valid,
    input  logic                    xclk_level,
    input  logic                    protect_pin,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    busy,
    output logic                    done
);

    page_req_t req_q;
    logic      accept;
    logic      allow;
    logic      fire;
    logic      lock_w;

    assign accept = commit & ~busy;

    // The request is held for the whole interval; inputs may move freely.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.base  <= base_addr;
            req_q.valid <= byte_valid;
            req_q.bytes <= page_bytes;
        end
    end

    wpc_permit u_permit (
        .clk         (clk),
        .rst         (rst),
        .xclk_level  (xclk_level),
        .protect_pin (protect_pin),
        .fire        (fire),
        .base        (req_q.base),
        .valid       (req_q.valid),
        .allow       (allow),
        .lock        (lock_w)
    );

    wpc_timer #(
        .WR_CYCLES     (WR_CYCLES),
        .BUSY_ON_BLOCK (BUSY_ON_BLOCK)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .grant (allow),
        .busy  (busy),
        .fire  (fire),
        .done  (done)
    );

    wpc_array u_array (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .req     (req_q),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
    parameter int WR_CYCLES = 16
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic fire,
    input logic lock
);

    int unsigned busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    // R6: the busy run never exceeds the programming interval
    assert_busy_len_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < WR_CYCLES));

    // R6: leaving the interval always comes with the done pulse
    assert_fall_done_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R6: done is never raised while still programming
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R3: lock bit is sticky
    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        lock |=> lock);

    // R3: lock only rises from an array write that just completed
    assert_lock_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> ($past(fire) && done));

    // R7: the array write happens inside the interval and ends it
    assert_fire_end_R7: assert property (@(posedge clk) disable iff (rst)
        fire |=> (!busy && done));

endmodule

bind wprot_prog_ctrl wpc_checker #(.WR_CYCLES(WR_CYCLES)) u_wpc_checker (
    .clk  (clk),
    .rst  (rst),
    .busy (busy),
    .done (done),
    .fire (fire),
    .lock (lock_w)
);

// File: tb/wprot_prog_ctrl_bench.sv
`timescale 1ns/1ps
module wprot_prog_ctrl_bench;

    localparam int W = 12;

    logic        clk = 1'b0;
    logic        rst;
    logic        commit;
    logic [6:0]  base_addr;
    logic [63:0] page_bytes;
    logic [7:0]  byte_valid;
    logic        xclk_level;
    logic        protect_pin;
    logic [6:0]  rd_addr;
    logic [7:0]  rd_data;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] mem_m [128];
    logic       lock_m;

    always #2.5 clk = ~clk;

    wprot_prog_ctrl #(.WR_CYCLES(W), .BUSY_ON_BLOCK(1'b0)) u_wprot_prog_ctrl (
        .clk, .rst, .commit, .base_addr, .page_bytes, .byte_valid,
        .xclk_level, .protect_pin, .rd_addr, .rd_data, .busy, .done
    );

    function automatic logic [6:0] tgt(logic [6:0] b, int k);
        logic [2:0] lo;
        lo = b[2:0] + 3'(k);
        return {b[6:3], lo};
    endfunction

    function automatic logic permitted(logic xc, logic pr, logic lk);
        return xc && (!lk || pr);
    endfunction

    task automatic check(bit cond, string req, int act, int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R10: combinational read sweep against the model
    task automatic sweep(string req);
        int bad = 0;
        int first_act = 0;
        int first_exp = 0;
        for (int a = 0; a < 128; a++) begin
            rd_addr = 7'(a);
            #0.01;
            if (rd_data !== mem_m[a]) begin
                if (bad == 0) begin
                    first_act = int'(rd_data);
                    first_exp = int'(mem_m[a]);
                end
                bad++;
            end
        end
        check(bad == 0, req, first_act, first_exp);
    endtask

    task automatic run_commit(logic [6:0] b, logic [63:0] d, logic [7:0] v,
                              logic xc, logic pr, bit drop, bit poke, string req);
        logic ok;
        int   n;
        ok = permitted(xc, pr, lock_m);
        @(negedge clk);
        base_addr = b; page_bytes = d; byte_valid = v;
        xclk_level = xc; protect_pin = pr; commit = 1'b1;
        @(negedge clk);                       // E0 has sampled the commit
        commit = 1'b0;
        if (drop) begin                       // R7: inputs move during the interval
            xclk_level  = 1'b0;
            protect_pin = ~pr;
            base_addr   = ~b;
            page_bytes  = ~d;
            byte_valid  = ~v;
        end
        if (ok) begin
            n = 0;
            while (busy && n < 4 * W) begin
                n++;
                commit = (poke && n == 3);    // R7: strobe while busy is ignored
                @(negedge clk);
                commit = 1'b0;
            end
            check(n == W, {req, " R6 busy length"}, n, W);
            check(done == 1'b1, {req, " R6 done pulse"}, int'(done), 1);
            for (int k = 0; k < 8; k++) begin
                if (v[k]) begin
                    mem_m[tgt(b, k)] = d[k*8 +: 8];
                    if (tgt(b, k) == 7'h7F) lock_m = 1'b1;
                end
            end
        end else begin
            check(busy == 1'b0, {req, " R8 busy on refusal"}, int'(busy), 0);
            check(done == 1'b1, {req, " R8 done on refusal"}, int'(done), 1);
        end
        sweep({req, " R5 array contents"});
        xclk_level = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; commit = 1'b0; base_addr = '0; page_bytes = '0;
        byte_valid = '0; xclk_level = 1'b1; protect_pin = 1'b1; rd_addr = '0;
        for (int a = 0; a < 128; a++) mem_m[a] = 8'h00;
        lock_m = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        check(busy == 1'b0, "R9 busy after reset", int'(busy), 0);
        check(done == 1'b0, "R9 done after reset", int'(done), 0);
        sweep("R9 array cleared");

        // R2: lock clear, protect low still writes
        run_commit(7'h10, 64'h8877665544332211, 8'hFF, 1'b1, 1'b0, 0, 0, "R2 unlocked write");
        // R5: wrapping base with sparse mask
        run_commit(7'h1D, 64'hA1B2C3D4E5F60718, 8'b0010_0111, 1'b1, 1'b1, 0, 0, "R5 wrap");
        // R1: transmit clock low refuses
        run_commit(7'h20, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0, 1'b1, 0, 0, "R1 xclk low");
        // R3 + R7: write to 7Fh sets lock; inputs change and a strobe arrives mid-interval
        run_commit(7'h7E, 64'h0000_0000_0000_5A00, 8'b0000_0010, 1'b1, 1'b1, 1, 1, "R3 lock set R7");
        // R4: locked, protect low refuses
        run_commit(7'h30, 64'h0102030405060708, 8'hFF, 1'b1, 1'b0, 0, 0, "R4 locked pin low");
        // R4: locked, protect high writes
        run_commit(7'h33, 64'h1112131415161718, 8'hF0, 1'b1, 1'b1, 0, 0, "R4 locked pin high");
        // R3: lock persists after further writes
        run_commit(7'h40, 64'hDEADBEEFCAFEF00D, 8'hFF, 1'b1, 1'b0, 0, 0, "R3 lock sticky");
        // R1: xclk low with locked and pin high
        run_commit(7'h7F, 64'h55, 8'h01, 1'b0, 1'b1, 0, 0, "R1 xclk low locked");

        // Random mix
        for (int i = 0; i < 60; i++) begin
            logic [6:0]  rb;
            logic [63:0] rdat;
            logic [7:0]  rv;
            rb   = 7'($urandom);
            rdat = {$urandom, $urandom};
            rv   = 8'($urandom);
            run_commit(rb, rdat, rv, ($urandom % 4) != 0, 1'($urandom),
                       1'($urandom), 1'($urandom), "R5 random");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule